// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block stores incoming Ethernet frames into a circular region of local packet memory. The memory is divided into 256-byte pages. The ring is bounded by a programmable first page and a programmable end page, which is the first page past the ring. A byte stream delivers each frame. The block writes the frame body four bytes past the start of the current page. It pads the body with zeros up to the minimum frame size. Finally it writes a 4-byte header at the current page. The header links to the page where the next frame will begin.

Before it takes a frame, the block compares the free space between the current page and the host's boundary page against one maximum-size frame. If the space is too small, or the receiver is halted, the whole frame is consumed and discarded. Once a frame has been accepted it is never back-pressured: `in_ready` stays high for every byte of the body. `in_ready` drops only during padding and header writes, which come after the last byte. At the end of a stored frame the current page moves to the linked page and a receive-done flag is raised. The flag drives an interrupt line through an enable.

Top module: `rx_ring_writer`

## Requirements
- R1: A byte address is the page number times 256. The first body byte of an accepted frame is written at current page × 256 + 4, and following bytes go to consecutive addresses.
- R2: At the first byte (`in_first`) the free space is computed. If current < boundary, it is (boundary − current) pages; otherwise it is (end − first) − (current − boundary) pages. `full` is high when this space is below 1518 bytes. A frame that starts while `full` is high writes nothing and leaves the current page unchanged.
- R3: A frame that starts while `cmd_stop` is high writes nothing and leaves the current page and the receive-done flag unchanged.
- R4: A body shorter than 60 bytes is followed by zero bytes up to 60 stored bytes.
- R5: After the body, the header is written at current page × 256 + 0..3, in this order: status byte at offset 0, next page at offset 1, total length low byte at offset 2, total length high byte at offset 3. Total length is the stored body length plus 4.
- R6: Status bit 0 is always 1. Status bit 5 is 1 when bit 0 of the first body byte is 1 (group address); every other status bit is 0.
- R7: Next page = current + ceil((total length + 4) / 256). If the result is at or beyond the end page, the ring size (end − first) is subtracted.
- R8: When a body or pad write address reaches end page × 256, it continues at first page × 256. Every write falls inside the ring.
- R9: After the last header byte, `cur_page` takes the next-page value and `rx_flag` is set. `rx_flag_clr` clears the flag, but a set in the same cycle wins. `irq` is `rx_flag` AND `rx_irq_en`. `cur_page` otherwise changes only through `cur_load` while the block is not busy.
- R10: `in_ready` is high when idle, while receiving a body, and while discarding a refused frame. It is low only during padding and header writes. A byte transfers when `in_valid` and `in_ready` are both high at a rising clock edge.
- R11: Memory writes are registered: a write appears on `mem_we`/`mem_addr`/`mem_wdata` one cycle after its decision. `busy` is high from the accepted first byte through the last header decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stop | input | 1 | Receiver halted; new frames are refused |
| pg_start | input | 8 | First page of the ring |
| pg_stop | input | 8 | Page just past the ring |
| pg_bound | input | 8 | Boundary page (host read pointer) |
| cur_load | input | 1 | Load `cur_load_val` into the current page (ignored while busy) |
| cur_load_val | input | 8 | Current page value to load |
| rx_flag_clr | input | 1 | Clear the receive-done flag |
| rx_irq_en | input | 1 | Interrupt enable for the receive-done flag |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted when high with `in_valid` |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_page | output | 8 | Current page |
| rx_flag | output | 1 | Receive-done status flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | A frame is being stored |
| full | output | 1 | Free space below one maximum frame |

## Verification
The hardest cases to reach from the ports are a body that crosses the end page, and a free-space boundary that sits exactly at one page more or less than a maximum frame. The stimulus loads the current page directly onto the last page of the ring and sends a 300-byte frame, so the body wraps and the linked page also wraps. It then moves the boundary page so that the free space is five pages (refused) and then six pages (accepted). A scoreboard model of every expected memory write, built from the rules above, catches any stray or misplaced write byte by byte.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BODY,
    ST_DROP,
    ST_PAD,
    ST_HDR
  } rxr_state_t;

  localparam logic [7:0] STAT_GOOD  = 8'h01;
  localparam logic [7:0] STAT_GROUP = 8'h20;
  localparam int HDR_BYTES  = 4;
  localparam int TAIL_BYTES = 4;
endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int PAGE_W    = 8,
  parameter int MAX_FRAME = 1518
) (
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic [PAGE_W-1:0] bound_pg,
  input  logic [PAGE_W-1:0] cur_pg,
  output logic              full
);
  localparam int SW = PAGE_W + 9;
  logic [SW-1:0] free_bytes;

  always_comb begin
    if (cur_pg < bound_pg)
      free_bytes = SW'(bound_pg - cur_pg) << 8;
    else
      free_bytes = (SW'(stop_pg - start_pg) - SW'(cur_pg - bound_pg)) << 8;
    full = free_bytes < SW'(MAX_FRAME);
  end
endmodule

// File: rtl/rxr_nextpg.sv
module rxr_nextpg #(
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 11
) (
  input  logic [PAGE_W-1:0] cur_pg,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic [LEN_W-1:0]  total_len,
  output logic [PAGE_W-1:0] next_pg
);
  import rxr_pkg::*;
  localparam int NW = PAGE_W + 1;
  localparam logic [LEN_W:0] ROUND_ADD = (LEN_W+1)'(TAIL_BYTES + 255);
  logic [NW-1:0] raw;

  always_comb begin
    raw = {1'b0, cur_pg} + NW'(({1'b0, total_len} + ROUND_ADD) >> 8);
    if (raw >= {1'b0, stop_pg})
      raw = raw - NW'(stop_pg - start_pg);
    next_pg = raw[PAGE_W-1:0];
  end
endmodule

// File: rtl/rxr_wptr.sv
module rxr_wptr #(
  parameter int PAGE_W = 8,
  localparam int AW    = PAGE_W + 8
) (
  input  logic [AW-1:0]     addr,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  output logic [AW-1:0]     addr_inc
);
  logic [AW-1:0] sum;
  always_comb begin
    sum      = addr + AW'(1);
    addr_inc = (sum == {stop_pg, 8'h00}) ? {start_pg, 8'h00} : sum;
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int PAGE_W    = 8,
  parameter int LEN_W     = 11,
  parameter int MAX_FRAME = 1518,
  parameter int MIN_FRAME = 60,
  localparam int AW       = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stop,
  input  logic [PAGE_W-1:0] pg_start,
  input  logic [PAGE_W-1:0] pg_stop,
  input  logic [PAGE_W-1:0] pg_bound,
  input  logic              cur_load,
  input  logic [PAGE_W-1:0] cur_load_val,
  input  logic              rx_flag_clr,
  input  logic              rx_irq_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [7:0]        in_data,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [PAGE_W-1:0] cur_page,
  output logic              rx_flag,
  output logic              irq,
  output logic              busy,
  output logic              full
);
  import rxr_pkg::*;

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] HDR_L = LEN_W'(HDR_BYTES);

  rxr_state_t        st;
  logic [AW-1:0]     wptr, wptr_inc, base;
  logic [LEN_W-1:0]  len, len_p1, total;
  logic [PAGE_W-1:0] cur_q, next_pg;
  logic [1:0]        hcnt;
  logic              grp, flag, fire;
  logic [7:0]        hdr_byte;

  assign in_ready = (st == ST_IDLE) || (st == ST_BODY) || (st == ST_DROP);
  assign busy     = (st == ST_BODY) || (st == ST_PAD) || (st == ST_HDR);
  assign fire     = in_valid && in_ready;
  assign base     = {cur_q, 8'h00};
  assign len_p1   = len + LEN_W'(1);
  assign total    = len + HDR_L;
  assign cur_page = cur_q;
  assign rx_flag  = flag;
  assign irq      = flag && rx_irq_en;

  rxr_space #(.PAGE_W(PAGE_W), .MAX_FRAME(MAX_FRAME)) u_space (
    .start_pg(pg_start), .stop_pg(pg_stop), .bound_pg(pg_bound),
    .cur_pg(cur_q), .full(full));

  rxr_nextpg #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_next (
    .cur_pg(cur_q), .start_pg(pg_start), .stop_pg(pg_stop),
    .total_len(total), .next_pg(next_pg));

  rxr_wptr #(.PAGE_W(PAGE_W)) u_wptr (
    .addr(wptr), .start_pg(pg_start), .stop_pg(pg_stop), .addr_inc(wptr_inc));

  always_comb begin
    case (hcnt)
      2'd0:    hdr_byte = STAT_GOOD | (grp ? STAT_GROUP : 8'h00);
      2'd1:    hdr_byte = 8'(next_pg);
      2'd2:    hdr_byte = total[7:0];
      default: hdr_byte = 8'(total >> 8);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      wptr      <= '0;
      len       <= '0;
      grp       <= 1'b0;
      hcnt      <= '0;
      cur_q     <= '0;
      flag      <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (rx_flag_clr) flag <= 1'b0;
      if (cur_load && !busy) cur_q <= cur_load_val;
      case (st)
        ST_IDLE: begin
          if (fire && in_first) begin
            if (cmd_stop || full) begin
              st <= in_last ? ST_IDLE : ST_DROP;
            end else begin
              mem_we    <= 1'b1;
              mem_addr  <= base + AW'(HDR_BYTES);
              mem_wdata <= in_data;
              wptr      <= base + AW'(HDR_BYTES + 1);
              grp       <= in_data[0];
              len       <= LEN_W'(1);
              hcnt      <= '0;
              if (!in_last)                 st <= ST_BODY;
              else if (LEN_W'(1) < MIN_L)   st <= ST_PAD;
              else                          st <= ST_HDR;
            end
          end
        end
        ST_BODY: begin
          if (fire) begin
            mem_we    <= 1'b1;
            mem_addr  <= wptr;
            mem_wdata <= in_data;
            wptr      <= wptr_inc;
            len       <= len_p1;
            if (in_last) st <= (len_p1 < MIN_L) ? ST_PAD : ST_HDR;
          end
        end
        ST_DROP: begin
          if (fire && in_last) st <= ST_IDLE;
        end
        ST_PAD: begin
          mem_we    <= 1'b1;
          mem_addr  <= wptr;
          mem_wdata <= 8'h00;
          wptr      <= wptr_inc;
          len       <= len_p1;
          if (len_p1 >= MIN_L) st <= ST_HDR;
        end
        ST_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= base + AW'(hcnt);
          mem_wdata <= hdr_byte;
          hcnt      <= hcnt + 2'd1;
          if (hcnt == 2'd3) begin
            cur_q <= next_pg;
            flag  <= 1'b1;
            st    <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int PAGE_W = 8,
  localparam int AW    = PAGE_W + 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_stop,
  input logic              full,
  input logic              in_valid,
  input logic              in_first,
  input logic              in_ready,
  input logic              busy,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [PAGE_W-1:0] pg_start,
  input logic [PAGE_W-1:0] pg_stop,
  input logic [PAGE_W-1:0] cur_page,
  input logic              cur_load,
  input logic              rx_flag
);
  assert_refuse_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && in_valid && in_ready && in_first && full) |=> !busy);

  assert_refuse_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && in_valid && in_ready && in_first && cmd_stop) |=> !busy);

  assert_write_in_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= {pg_start, 8'h00}) && (mem_addr < {pg_stop, 8'h00}));

  assert_cur_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_page != $past(cur_page)) |-> ($past(cur_load) || $past(busy)));

  assert_flag_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> ($past(busy) && !busy));

  assert_ready_low_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> busy);

  assert_write_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy || $past(busy)));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_stop(cmd_stop), .full(full),
  .in_valid(in_valid), .in_first(in_first), .in_ready(in_ready), .busy(busy),
  .mem_we(mem_we), .mem_addr(mem_addr), .pg_start(pg_start), .pg_stop(pg_stop),
  .cur_page(cur_page), .cur_load(cur_load), .rx_flag(rx_flag));

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_stop = 1'b0;
  logic [7:0]  pg_start = 8'h40, pg_stop = 8'h60, pg_bound = 8'h40;
  logic        cur_load = 1'b0;
  logic [7:0]  cur_load_val = 8'h00;
  logic        rx_flag_clr = 1'b0, rx_irq_en = 1'b1;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, mem_we, rx_flag, irq, busy, full;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_page;

  int checks = 0, fails = 0, writes_seen = 0;
  logic [15:0] q_addr[$];
  logic [7:0]  q_data[$];
  string       cur_tag = "R1";
  logic [7:0]  exp_cur;

  always #5 clk = ~clk;

  rx_ring_writer i_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .cmd_stop(cmd_stop), .pg_start(pg_start),
    .pg_stop(pg_stop), .pg_bound(pg_bound), .cur_load(cur_load),
    .cur_load_val(cur_load_val), .rx_flag_clr(rx_flag_clr), .rx_irq_en(rx_irq_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first), .in_last(in_last),
    .in_data(in_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_page(cur_page), .rx_flag(rx_flag), .irq(irq), .busy(busy), .full(full));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every memory write
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      writes_seen++;
      if (q_addr.size() == 0) begin
        chk(1'b0, {cur_tag, " unexpected write"}, {16'h0, mem_addr}, 32'h0);
      end else begin
        logic [15:0] ea;
        logic [7:0]  ed;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        chk(mem_addr == ea, {cur_tag, " addr"}, {16'h0, mem_addr}, {16'h0, ea});
        chk(mem_wdata == ed, {cur_tag, " data"}, {24'h0, mem_wdata}, {24'h0, ed});
      end
    end
  end

  function automatic logic [7:0] fbyte(input logic [7:0] b0, input int i);
    return (i == 0) ? b0 : 8'((i * 7 + 3) & 255);
  endfunction

  task automatic load_cur(input logic [7:0] v);
    @(negedge clk);
    cur_load = 1'b1; cur_load_val = v;
    @(negedge clk);
    cur_load = 1'b0;
    exp_cur = v;
  endtask

  task automatic send_frame(input int n, input logic [7:0] b0, input bit accept,
                            input string tag);
    int plen, tot, npg;
    logic [15:0] a;
    cur_tag = tag;
    plen = (n < 60) ? 60 : n;
    tot  = plen + 4;
    if (accept) begin
      a = {exp_cur, 8'h00} + 16'd4;
      for (int i = 0; i < plen; i++) begin
        q_addr.push_back(a);
        q_data.push_back((i < n) ? fbyte(b0, i) : 8'h00);
        a = a + 16'd1;
        if (a == {pg_stop, 8'h00}) a = {pg_start, 8'h00};
      end
      npg = int'(exp_cur) + (tot + 4 + 255) / 256;
      if (npg >= int'(pg_stop)) npg = npg - (int'(pg_stop) - int'(pg_start));
      q_addr.push_back({exp_cur, 8'h00});
      q_data.push_back(8'h01 | (b0[0] ? 8'h20 : 8'h00));
      q_addr.push_back({exp_cur, 8'h01});
      q_data.push_back(8'(npg));
      q_addr.push_back({exp_cur, 8'h02});
      q_data.push_back(8'(tot));
      q_addr.push_back({exp_cur, 8'h03});
      q_data.push_back(8'(tot >> 8));
      exp_cur = 8'(npg);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_first = (i == 0); in_last = (i == n - 1);
      in_data = fbyte(b0, i);
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    if (accept && n < 60)
      chk(!in_ready, "R10 ready low while padding", {31'h0, in_ready}, 32'h0);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(q_addr.size() == 0, {tag, " all writes seen"}, q_addr.size(), 0);
    chk(cur_page == exp_cur, "R9 current page", {24'h0, cur_page}, {24'h0, exp_cur});
  endtask

  task automatic clear_flag;
    @(negedge clk);
    rx_flag_clr = 1'b1;
    @(negedge clk);
    rx_flag_clr = 1'b0;
  endtask

  initial begin
    int w0;
    exp_cur = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_page == 8'h00, "R9 reset cur_page", {24'h0, cur_page}, 32'h0);
    chk(!irq && !rx_flag, "R9 reset irq", {30'h0, irq, rx_flag}, 32'h0);
    chk(!busy && !mem_we, "R11 reset idle", {30'h0, busy, mem_we}, 32'h0);
    chk(in_ready, "R10 reset ready", {31'h0, in_ready}, 32'h1);

    load_cur(8'h40);
    // R1 R5 R6 R7: unicast 100-byte frame
    send_frame(100, 8'h00, 1'b1, "R1");
    chk(rx_flag && irq, "R9 flag and irq", {30'h0, rx_flag, irq}, 32'h3);
    clear_flag();
    chk(!rx_flag && !irq, "R9 flag clear", {30'h0, rx_flag, irq}, 32'h0);

    // R4 R6: short group-address frame padded to 60
    send_frame(10, 8'h01, 1'b1, "R4");

    // R8 R7: body and next page both wrap
    pg_bound = 8'h50;
    load_cur(8'h5F);
    send_frame(300, 8'h02, 1'b1, "R8");
    chk(cur_page == 8'h41, "R7 wrapped next page", {24'h0, cur_page}, 32'h41);

    // R2: five free pages refused, six accepted
    clear_flag();
    pg_bound = 8'h45;
    load_cur(8'h40);
    chk(full, "R2 full at 5 pages", {31'h0, full}, 32'h1);
    w0 = writes_seen;
    send_frame(20, 8'h00, 1'b0, "R2");
    chk(writes_seen == w0, "R2 no writes when full", writes_seen, w0);
    chk(!rx_flag, "R2 flag untouched", {31'h0, rx_flag}, 32'h0);
    pg_bound = 8'h46;
    @(negedge clk);
    chk(!full, "R2 not full at 6 pages", {31'h0, full}, 32'h0);
    send_frame(60, 8'h03, 1'b1, "R5");

    // R3: halted receiver
    clear_flag();
    cmd_stop = 1'b1;
    pg_bound = 8'h40;
    w0 = writes_seen;
    send_frame(70, 8'h00, 1'b0, "R3");
    chk(writes_seen == w0, "R3 no writes when halted", writes_seen, w0);
    chk(!rx_flag, "R3 flag untouched", {31'h0, rx_flag}, 32'h0);
    cmd_stop = 1'b0;

    // R9: enable off masks the interrupt
    rx_irq_en = 1'b0;
    send_frame(61, 8'h04, 1'b1, "R6");
    chk(rx_flag && !irq, "R9 masked irq", {30'h0, rx_flag, irq}, 32'h2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule